// File: doc/BRIEF.md
# Word-Line Activation Guard

This block sits beside a memory address decoder and watches its one-hot word-line outputs during each access. It does not duplicate the decoder. It runs two cheap tests. The first takes the XOR of the upper half of the word lines and the XOR of the lower half. These two bits form a dual-rail pair, and a legal one-hot word makes them complementary. The second ORs every word line whose index has an even number of ones. That result must disagree with the address parity bit supplied alongside the address, so it forms a second dual-rail pair. A two-rail merge tree folds both pairs into one pair. That pair stays complementary only while every input pair is complementary.

The checks count only while the access strobe is high, so an idle decoder with every line low raises nothing. The first failing access latches a registered dual-rail error output. The output reads `01` while healthy and `10` once a fault has been seen, and it holds `10` until synchronous reset. A gated write enable passes a write request to the array only when three things hold: the strobe is active, the check of the current cycle is clean, and no fault is latched. A write that would land on a misdecoded row is therefore blocked in the same cycle.

Top module: `wordline_guard`

## Requirements
- R1: After synchronous reset `err_rail` reads `2'b01` (bit 1 = fault rail, bit 0 = healthy rail), and `mem_we` is 0 whenever `acc_stb` is 0.
- R2: With `acc_stb` high, exactly one word line active, and `addr_par` equal to the XOR of that line's index bits, `err_rail` stays `2'b01`.
- R3: With `acc_stb` high and no word line active, `err_rail` becomes `2'b10` at the next rising clock edge.
- R4: With `acc_stb` high and exactly two word lines active (in the same half or in different halves), `err_rail` becomes `2'b10` at the next rising clock edge.
- R5: With `acc_stb` high, a single active line, and an index parity that differs from `addr_par` (the wrong line was selected), `err_rail` becomes `2'b10` at the next rising clock edge.
- R6: While `acc_stb` is low, `wl_sel` and `addr_par` are ignored: `err_rail` does not change.
- R7: Once `err_rail` reads `2'b10` it keeps that value until `rst` is asserted, whatever the inputs do.
- R8: `mem_we` is high exactly when `acc_stb` and `wr_req` are high, the current cycle's check is clean, and no fault is latched. A faulty access therefore has its write suppressed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | Access strobe; the checks count only while it is high |
| wr_req | input | 1 | Write request from the bus side |
| addr_par | input | 1 | XOR of all address bits of the current access |
| wl_sel | input | N_LINES | Word-line outputs of the decoder under watch |
| mem_we | output | 1 | Gated write enable to the storage array |
| err_rail | output | 2 | Registered dual-rail status: 01 healthy, 10 fault latched |

## Verification
A broken merge tree, half-XOR pair or parity pair would show up at the ports in one of two ways. Either `err_rail` fails to move to `10` on the edge after a bad access, or it moves there after a clean one. The registered status lags the offending access by exactly one clock, while the write gate reacts in the same cycle. The bench therefore checks `mem_we` within the access cycle and `err_rail` one edge later. A latch that loses its state would appear as `10` falling back to `01` with no reset, and a stuck latch would appear as `10` surviving a reset.

// File: rtl/wordline_guard_pkg.sv
package wordline_guard_pkg;

    // A dual-rail pair; a healthy pair has hi != lo.
    typedef struct packed {
        logic hi;
        logic lo;
    } rail_t;

    localparam rail_t RAIL_HEALTHY = '{hi: 1'b0, lo: 1'b1};
    localparam rail_t RAIL_FAULT   = '{hi: 1'b1, lo: 1'b0};

    // Two-rail merge: the result is complementary only if both inputs are.
    function automatic rail_t rail_merge(input rail_t a, input rail_t b);
        rail_t z;
        z.hi = (a.hi & b.hi) | (a.lo & b.lo);
        z.lo = (a.hi & b.lo) | (a.lo & b.hi);
        return z;
    endfunction

    function automatic logic rail_valid(input rail_t r);
        return r.hi ^ r.lo;
    endfunction

    // Parity of a constant index, used while elaborating.
    function automatic bit index_odd(input int unsigned idx);
        bit p;
        p = 1'b0;
        for (int b = 0; b < 32; b++) begin
            p = p ^ idx[b];
        end
        return p;
    endfunction

endpackage

// File: rtl/wordline_guard_halves.sv
module wordline_guard_halves
    import wordline_guard_pkg::*;
#(
    parameter int N_LINES = 16,
    localparam int HALF = N_LINES / 2
) (
    input  logic [N_LINES-1:0] wl_sel,
    output rail_t              pair
);
    logic upper_x;
    logic lower_x;

    always_comb begin
        upper_x = ^wl_sel[N_LINES-1:HALF];
        lower_x = ^wl_sel[HALF-1:0];
        pair.hi = upper_x;
        pair.lo = lower_x;
    end
endmodule

// File: rtl/wordline_guard_parity.sv
module wordline_guard_parity
    import wordline_guard_pkg::*;
#(
    parameter int N_LINES = 16
) (
    input  logic [N_LINES-1:0] wl_sel,
    input  logic               addr_par,
    output rail_t              pair
);
    logic [N_LINES-1:0] even_mask;

    for (genvar i = 0; i < N_LINES; i++) begin : g_mask
        if (index_odd(i)) begin : g_odd
            assign even_mask[i] = 1'b0;
        end else begin : g_even
            assign even_mask[i] = 1'b1;
        end
    end

    logic even_hit;

    always_comb begin
        even_hit = |(wl_sel & even_mask);
        pair.hi  = even_hit;
        pair.lo  = addr_par;
    end
endmodule

// File: rtl/wordline_guard_tree.sv
module wordline_guard_tree
    import wordline_guard_pkg::*;
#(
    parameter int N_PAIRS = 2
) (
    input  rail_t [N_PAIRS-1:0] pairs,
    output rail_t               merged
);
    rail_t [N_PAIRS-1:0] chain;

    assign chain[0] = pairs[0];
    for (genvar i = 1; i < N_PAIRS; i++) begin : g_link
        assign chain[i] = rail_merge(chain[i-1], pairs[i]);
    end

    assign merged = chain[N_PAIRS-1];
endmodule

// File: rtl/wordline_guard.sv
module wordline_guard
    import wordline_guard_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int N_LINES = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_stb,
    input  logic               wr_req,
    input  logic               addr_par,
    input  logic [N_LINES-1:0] wl_sel,
    output logic               mem_we,
    output logic [1:0]         err_rail
);
    localparam int N_PAIRS = 2;

    rail_t [N_PAIRS-1:0] pairs;
    rail_t               merged;
    rail_t               status_q;
    logic                live_ok;

    wordline_guard_halves #(.N_LINES(N_LINES)) halves_i (
        .wl_sel (wl_sel),
        .pair   (pairs[0])
    );

    wordline_guard_parity #(.N_LINES(N_LINES)) parity_i (
        .wl_sel   (wl_sel),
        .addr_par (addr_par),
        .pair     (pairs[1])
    );

    wordline_guard_tree #(.N_PAIRS(N_PAIRS)) tree_i (
        .pairs  (pairs),
        .merged (merged)
    );

    assign live_ok = rail_valid(merged);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= RAIL_HEALTHY;
        end else if (acc_stb && !live_ok) begin
            status_q <= RAIL_FAULT;
        end
    end

    assign mem_we   = acc_stb & wr_req & live_ok & ~status_q.hi;
    assign err_rail = status_q;
endmodule

// File: rtl/wordline_guard_chk.sv
module wordline_guard_chk #(
    parameter int N_LINES = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_stb,
    input logic               wr_req,
    input logic               addr_par,
    input logic [N_LINES-1:0] wl_sel,
    input logic               mem_we,
    input logic [1:0]         err_rail
);
    logic sel_idx_par;

    always_comb begin
        sel_idx_par = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (wl_sel[i]) sel_idx_par = sel_idx_par ^ (^i);
        end
    end

    assert_rail_legal_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(err_rail) == 1);

    assert_idle_no_write_R1: assert property (@(posedge clk) disable iff (rst)
        !acc_stb |-> !mem_we);

    assert_good_keeps_ok_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && $countones(wl_sel) == 1 && sel_idx_par == addr_par && err_rail == 2'b01)
        |=> err_rail == 2'b01);

    assert_empty_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && wl_sel == '0) |=> err_rail == 2'b10);

    assert_double_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && $countones(wl_sel) == 2) |=> err_rail == 2'b10);

    assert_parity_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (acc_stb && $countones(wl_sel) == 1 && sel_idx_par != addr_par) |=> err_rail == 2'b10);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !acc_stb |=> $stable(err_rail));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_rail == 2'b10 |=> err_rail == 2'b10);

    assert_we_gate_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (acc_stb && wr_req && err_rail == 2'b01 && $countones(wl_sel) == 1));
endmodule

bind wordline_guard wordline_guard_chk #(.N_LINES(N_LINES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .acc_stb  (acc_stb),
    .wr_req   (wr_req),
    .addr_par (addr_par),
    .wl_sel   (wl_sel),
    .mem_we   (mem_we),
    .err_rail (err_rail)
);

// File: tb/wordline_guard_tb_top.sv
`timescale 1ns/1ps
module wordline_guard_tb_top;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         acc_stb = 1'b0;
    logic         wr_req = 1'b0;
    logic         addr_par = 1'b0;
    logic [N-1:0] wl_sel = '0;
    logic         mem_we;
    logic [1:0]   err_rail;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  m_fault = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    wordline_guard #(.ADDR_W(AW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .acc_stb  (acc_stb),
        .wr_req   (wr_req),
        .addr_par (addr_par),
        .wl_sel   (wl_sel),
        .mem_we   (mem_we),
        .err_rail (err_rail)
    );

    function automatic bit par_of(input int v);
        bit p = 0;
        for (int b = 0; b < AW; b++) p ^= v[b];
        return p;
    endfunction

    // Behavioural expectation: exactly one line, and its index parity matches.
    function automatic bit access_ok(input logic [N-1:0] w, input logic ap);
        int cnt = 0;
        int idx = 0;
        for (int i = 0; i < N; i++) if (w[i]) begin cnt++; idx = i; end
        return (cnt == 1) && (par_of(idx) == ap);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] w, input logic ap, input logic stb,
                        input logic wr, input string tag);
        logic [1:0] exp_err;
        logic       exp_we;
        @(negedge clk);
        exp_err = m_fault ? 2'b10 : 2'b01;
        check(err_rail === exp_err, tag, "err_rail", err_rail, exp_err);
        wl_sel = w; addr_par = ap; acc_stb = stb; wr_req = wr;
        #1;
        exp_we = stb & wr & access_ok(w, ap) & !m_fault;
        check(mem_we === exp_we, tag, "mem_we", mem_we, exp_we);
        @(posedge clk);
        if (stb && !access_ok(w, ap)) m_fault = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_stb = 1'b0; wr_req = 1'b0;
        @(posedge clk);
        m_fault = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [N-1:0] line(input int i);
        logic [N-1:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        // R1: reset state and idle write gate
        step('0, 1'b0, 1'b0, 1'b1, "R1");
        // R2: every legal address with matching parity, writes pass
        for (int a = 0; a < N; a++) step(line(a), par_of(a), 1'b1, 1'b1, "R2");
        // R6: illegal patterns while idle are ignored
        step('0, 1'b0, 1'b0, 1'b1, "R6");
        step(line(0) | line(N-1), 1'b0, 1'b0, 1'b1, "R6");
        step(line(3), 1'b1, 1'b0, 1'b0, "R6");
        step(line(5), par_of(5), 1'b1, 1'b1, "R6");
        // R3: no line active
        step('0, 1'b0, 1'b1, 1'b1, "R3");
        // R7: stays latched even on a clean access
        step(line(2), par_of(2), 1'b1, 1'b1, "R7");
        step('0, 1'b0, 1'b0, 1'b0, "R7");
        do_reset();
        // R4: two lines across halves
        step(line(1) | line(N-2), 1'b0, 1'b1, 1'b1, "R4");
        step(line(4), par_of(4), 1'b1, 1'b1, "R7");
        do_reset();
        // R4: two lines within one half
        step(line(0) | line(1), 1'b1, 1'b1, 1'b1, "R4");
        step('0, 1'b0, 1'b0, 1'b0, "R4");
        do_reset();
        // R5: wrong line selected, index parity mismatches
        step(line(6), ~par_of(6), 1'b1, 1'b1, "R5");
        step('0, 1'b0, 1'b0, 1'b0, "R5");
        do_reset();
        // R8: clean read passes no write, then a fault suppresses writes
        step(line(9), par_of(9), 1'b1, 1'b0, "R8");
        step(line(9), par_of(9), 1'b1, 1'b1, "R8");
        step(line(7), ~par_of(7), 1'b1, 1'b1, "R8");
        step(line(7), par_of(7), 1'b1, 1'b1, "R8");
        // Mixed random traffic
        for (int k = 0; k < 600; k++) begin
            int a = $urandom_range(0, N-1);
            int kind = $urandom_range(0, 9);
            logic wr = 1'($urandom_range(0, 1));
            if (m_fault && $urandom_range(0, 3) == 0) do_reset();
            case (kind)
                0: step('0, 1'($urandom_range(0, 1)), 1'b1, wr, "R3");
                1: step(line(a) | line((a + 1 + $urandom_range(0, N-2)) % N),
                        1'($urandom_range(0, 1)), 1'b1, wr, "R4");
                2: step(line(a ^ 1), par_of(a), 1'b1, wr, "R5");
                3: step(N'($urandom), 1'($urandom_range(0, 1)), 1'b0, wr, "R6");
                default: step(line(a), par_of(a), 1'b1, wr, "R2");
            endcase
        end
        step('0, 1'b0, 1'b0, 1'b0, "R7");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule